// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 64 pins. Pins are grouped 32 to a register set. Each set has four parts: a direction register, an output latch, a synchronized view of the pin levels, and edge-detection logic whose enables and status live in per-pin registers. Software never has to read, modify and write a register to change one pin. The output latch, the rising-edge enable and the falling-edge enable are each changed through a pair of write-one-to-set and write-one-to-clear addresses. Pending interrupts are acknowledged by writing ones to the status register.

Interrupt requests come out in two forms at the same time. In the first form, each 16-pin half of a register set is one interrupt bank. Bank n raises its line when any status bit in that half is pending and bit n of a global bank-enable register is set. In the second form, a parameter picks the first few pins for direct per-pin lines. These lines follow the pin's status bit directly, and those pins come out of reset with edge detection enabled on both edges.

The register bus is a simple single-cycle port: select, write strobe, byte address and write data, with read data returned in the same cycle. On the pin side, the block takes the pad levels and drives the output value and the output enable.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (direction all ones, pad_oe_o all zero), the output latch, status and bank-enable registers read zero, the rise and fall enables read zero except for the direct pins (both set), and every interrupt line is low.
- R2: The bank-enable register is at byte offset 0x08. Register set s starts at 0x10 + 0x28*s. Within a set the offsets are: +0x00 direction, +0x04 output latch (read only), +0x08 set-output, +0x0C clear-output, +0x10 input level (read only), +0x14/+0x18 set/clear rise enable, +0x1C/+0x20 set/clear fall enable, +0x24 status. The set/clear enable addresses read back the enable register.
- R3: Writing a mask to set-output drives the masked latch bits to 1, and writing one to clear-output drives them to 0. Zero bits leave their latch bits unchanged, and pad_out_o follows the latch. Pin p uses set p/32, bit p%32.
- R4: A direction bit of 1 makes the pin an input (pad_oe_o bit 0). A direction bit of 0 drives the latch onto the pin (pad_oe_o bit 1).
- R5: The input-level register returns the pad level, including for pins driven as outputs, through a two-flop synchronizer. A change becomes readable after the second rising clock edge.
- R6: A pin's status bit is set on a rising edge of its synchronized level if its rise enable is set, and on a falling edge if its fall enable is set. With both enables set, either edge sets the bit.
- R7: Writing ones to the status register clears those bits, and zero bits are unaffected. If a new edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: There are ceil(pins/16) bank lines. Line n covers set n/2, bits 16*(n%2) to 16*(n%2)+15, and is high exactly when a status bit in that range is set and bank-enable bit n is 1.
- R9: For each of the first DIRECT_N pins, pin_irq_o[i] equals that pin's status bit, independent of the bank-enable register.
- R10: Reads of unmapped addresses return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| pad_in_i | input | NUM_PINS | Pad levels |
| pad_out_o | output | NUM_PINS | Output latch values |
| pad_oe_o | output | NUM_PINS | Output enables |
| bank_irq_o | output | NUM_PINS/16 rounded up | Per-bank interrupt lines |
| pin_irq_o | output | max(DIRECT_N,1) | Direct per-pin interrupt lines |

## Verification
The output latch is driven by a table of overlapping set and clear masks, including a zero mask and a full mask, and this shows whether only the written bits move. Edge detection is tried with a fall-only pin, a both-edge pin and a pin whose rise enable is withdrawn, which separates the two polarities and the enable gating. A clear is timed to land in the same cycle as a new edge, and the same clear is repeated with no edge, so the edge-priority rule is told apart from plain clearing. Pins are also toggled in enabled and disabled banks and on direct pins while every bank is disabled, which shows the bank gating separately from the per-pin lines.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    localparam logic [7:0] BANK_EN_ADDR = 8'h08;
    localparam logic [7:0] SET_BASE0    = 8'h10;
    localparam logic [7:0] SET_SPAN     = 8'h28;

    typedef enum logic [3:0] {
        REG_DIR,
        REG_OUT,
        REG_SET_OUT,
        REG_CLR_OUT,
        REG_IN,
        REG_SET_RISE,
        REG_CLR_RISE,
        REG_SET_FALL,
        REG_CLR_FALL,
        REG_STAT,
        REG_NONE
    } reg_kind_e;

    typedef struct packed {
        logic              we;
        reg_kind_e         kind;
        logic [WORD_W-1:0] data;
    } set_cmd_t;

    function automatic logic [7:0] set_base(input int s);
        return SET_BASE0 + 8'(s) * SET_SPAN;
    endfunction

    function automatic reg_kind_e kind_of_offset(input logic [7:0] off);
        case (off)
            8'h00:   return REG_DIR;
            8'h04:   return REG_OUT;
            8'h08:   return REG_SET_OUT;
            8'h0C:   return REG_CLR_OUT;
            8'h10:   return REG_IN;
            8'h14:   return REG_SET_RISE;
            8'h18:   return REG_CLR_RISE;
            8'h1C:   return REG_SET_FALL;
            8'h20:   return REG_CLR_FALL;
            8'h24:   return REG_STAT;
            default: return REG_NONE;
        endcase
    endfunction

    // Bits of set s that belong to the first n (direct) pins.
    function automatic logic [WORD_W-1:0] direct_mask(input int s, input int n);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (s * WORD_W + i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
            prev_q <= '0;
        end else begin
            stg_q[0] <= raw_i;
            for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            prev_q <= stg_q[STAGES-1];
        end
    end

    assign level_o = stg_q[STAGES-1];
    assign rise_o  = stg_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gpio_regset.sv
module gpio_regset
    import gpio_pkg::*;
#(
    parameter logic [WORD_W-1:0] EDGE_RST = '0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  set_cmd_t          cmd_i,
    input  logic [WORD_W-1:0] level_i,
    input  logic [WORD_W-1:0] rise_i,
    input  logic [WORD_W-1:0] fall_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [WORD_W-1:0] out_o,
    output logic [WORD_W-1:0] oe_o,
    output logic [WORD_W-1:0] status_o
);
    logic [WORD_W-1:0] dir_q, out_q, rise_en_q, fall_en_q, stat_q;
    logic [WORD_W-1:0] hit, ack;

    assign hit = (rise_i & rise_en_q) | (fall_i & fall_en_q);
    assign ack = (cmd_i.we && cmd_i.kind == REG_STAT) ? cmd_i.data : '0;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            dir_q     <= '1;
            out_q     <= '0;
            rise_en_q <= EDGE_RST;
            fall_en_q <= EDGE_RST;
            stat_q    <= '0;
        end else begin
            if (cmd_i.we) begin
                case (cmd_i.kind)
                    REG_DIR:      dir_q     <= cmd_i.data;
                    REG_SET_OUT:  out_q     <= out_q | cmd_i.data;
                    REG_CLR_OUT:  out_q     <= out_q & ~cmd_i.data;
                    REG_SET_RISE: rise_en_q <= rise_en_q | cmd_i.data;
                    REG_CLR_RISE: rise_en_q <= rise_en_q & ~cmd_i.data;
                    REG_SET_FALL: fall_en_q <= fall_en_q | cmd_i.data;
                    REG_CLR_FALL: fall_en_q <= fall_en_q & ~cmd_i.data;
                    default: ;
                endcase
            end
            // a fresh edge overrides a simultaneous acknowledge
            stat_q <= (stat_q & ~ack) | hit;
        end
    end

    always_comb begin
        case (cmd_i.kind)
            REG_DIR:                    rdata_o = dir_q;
            REG_OUT, REG_SET_OUT,
            REG_CLR_OUT:                rdata_o = out_q;
            REG_IN:                     rdata_o = level_i;
            REG_SET_RISE, REG_CLR_RISE: rdata_o = rise_en_q;
            REG_SET_FALL, REG_CLR_FALL: rdata_o = fall_en_q;
            REG_STAT:                   rdata_o = stat_q;
            default:                    rdata_o = '0;
        endcase
    end

    assign out_o    = out_q;
    assign oe_o     = ~dir_q;
    assign status_o = stat_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DIRECT_N  = 4,
    parameter int ALL_W     = 64,
    localparam int DIRECT_W = (DIRECT_N > 0) ? DIRECT_N : 1
) (
    input  logic [ALL_W-1:0]     status_i,
    input  logic [NUM_BANKS-1:0] bank_en_i,
    output logic [NUM_BANKS-1:0] bank_irq_o,
    output logic [DIRECT_W-1:0]  pin_irq_o
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_irq_o[b] = bank_en_i[b] & (|status_i[b*HALF_W +: HALF_W]);
    end

    if (DIRECT_N > 0) begin : g_direct
        assign pin_irq_o = status_i[DIRECT_W-1:0];
    end else begin : g_nodirect
        assign pin_irq_o = 1'b0;
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int DIRECT_N = 4,
    localparam int NUM_SETS  = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int NUM_BANKS = (NUM_PINS + HALF_W - 1) / HALF_W,
    localparam int ALL_W     = NUM_SETS * WORD_W,
    localparam int DIRECT_W  = (DIRECT_N > 0) ? DIRECT_N : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_we_i,
    input  logic [7:0]           bus_addr_i,
    input  logic [WORD_W-1:0]    bus_wdata_i,
    output logic [WORD_W-1:0]    bus_rdata_o,
    input  logic [NUM_PINS-1:0]  pad_in_i,
    output logic [NUM_PINS-1:0]  pad_out_o,
    output logic [NUM_PINS-1:0]  pad_oe_o,
    output logic [NUM_BANKS-1:0] bank_irq_o,
    output logic [DIRECT_W-1:0]  pin_irq_o
);
    logic [ALL_W-1:0]     pad_ext, level_all, rise_all, fall_all;
    logic [ALL_W-1:0]     out_all, oe_all, stat_all;
    logic [WORD_W-1:0]    rd_set [NUM_SETS];
    logic [NUM_BANKS-1:0] bank_en_q;
    logic                 bank_en_hit;

    assign pad_ext = ALL_W'(pad_in_i);

    gpio_in_sync #(.W(ALL_W), .STAGES(2)) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .raw_i   (pad_ext),
        .level_o (level_all),
        .rise_o  (rise_all),
        .fall_o  (fall_all)
    );

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        localparam logic [7:0] BASE = set_base(s);
        logic     hit;
        set_cmd_t cmd;

        assign hit      = bus_sel_i && (bus_addr_i >= BASE) && (bus_addr_i < BASE + SET_SPAN);
        assign cmd.we   = hit && bus_we_i;
        assign cmd.kind = hit ? kind_of_offset(bus_addr_i - BASE) : REG_NONE;
        assign cmd.data = bus_wdata_i;

        gpio_regset #(.EDGE_RST(direct_mask(s, DIRECT_N))) set_i (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .cmd_i    (cmd),
            .level_i  (level_all[s*WORD_W +: WORD_W]),
            .rise_i   (rise_all[s*WORD_W +: WORD_W]),
            .fall_i   (fall_all[s*WORD_W +: WORD_W]),
            .rdata_o  (rd_set[s]),
            .out_o    (out_all[s*WORD_W +: WORD_W]),
            .oe_o     (oe_all[s*WORD_W +: WORD_W]),
            .status_o (stat_all[s*WORD_W +: WORD_W])
        );
    end

    assign bank_en_hit = bus_sel_i && (bus_addr_i == BANK_EN_ADDR);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            bank_en_q <= '0;
        end else if (bank_en_hit && bus_we_i) begin
            bank_en_q <= bus_wdata_i[NUM_BANKS-1:0];
        end
    end

    always_comb begin
        bus_rdata_o = bank_en_hit ? WORD_W'(bank_en_q) : '0;
        for (int s = 0; s < NUM_SETS; s++) bus_rdata_o = bus_rdata_o | rd_set[s];
    end

    gpio_irq_agg #(.NUM_BANKS(NUM_BANKS), .DIRECT_N(DIRECT_N), .ALL_W(ALL_W)) irq_i (
        .status_i   (stat_all),
        .bank_en_i  (bank_en_q),
        .bank_irq_o (bank_irq_o),
        .pin_irq_o  (pin_irq_o)
    );

    assign pad_out_o = out_all[NUM_PINS-1:0];
    assign pad_oe_o  = oe_all[NUM_PINS-1:0];
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int NUM_PINS  = 64,
    parameter int NUM_BANKS = 4
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 bus_sel_i,
    input logic                 bus_we_i,
    input logic [7:0]           bus_addr_i,
    input logic [WORD_W-1:0]    bus_wdata_i,
    input logic [NUM_PINS-1:0]  pad_out_o,
    input logic [NUM_PINS-1:0]  pad_oe_o,
    input logic [NUM_BANKS-1:0] bank_irq_o,
    input logic [NUM_BANKS-1:0] bank_en_q
);
    logic wr_set0, wr_clr0, wr_dir0;
    assign wr_set0 = bus_sel_i && bus_we_i && bus_addr_i == SET_BASE0 + 8'h08;
    assign wr_clr0 = bus_sel_i && bus_we_i && bus_addr_i == SET_BASE0 + 8'h0C;
    assign wr_dir0 = bus_sel_i && bus_we_i && bus_addr_i == SET_BASE0;

    assert_rst_inputs_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> pad_oe_o == '0);

    assert_set_data_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_set0 |=> (pad_out_o[WORD_W-1:0] & $past(bus_wdata_i)) == $past(bus_wdata_i));

    assert_clr_data_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_clr0 |=> (pad_out_o[WORD_W-1:0] & $past(bus_wdata_i)) == '0);

    assert_dir_oe_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_dir0 |=> pad_oe_o[WORD_W-1:0] == ~$past(bus_wdata_i));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_gate
        assert_bank_gate_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            bank_irq_o[b] |-> bank_en_q[b]);
    end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .NUM_BANKS(NUM_BANKS)) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .bank_irq_o  (bank_irq_o),
    .bank_en_q   (bank_en_q)
);

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb_top;
    localparam int NP = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel, we;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic [NP-1:0] ext, pad_in, pad_out, pad_oe;
    logic [3:0]  bank_irq, pin_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_bank_ctrl #(.NUM_PINS(NP), .DIRECT_N(4)) dut_i (
        .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .bank_irq_o(bank_irq), .pin_irq_o(pin_irq)
    );

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wval;
        logic [7:0]  raddr;
        logic [31:0] expect_v;
    } vec_t;

    // R3 latch vectors: set0 OUT=0x14 SET=0x18 CLR=0x1C, set1 OUT=0x3C SET=0x40 CLR=0x44
    localparam vec_t VECS [6] = '{
        '{8'h18, 32'hA5A5_0000, 8'h14, 32'hA5A5_0000},
        '{8'h18, 32'h0000_00FF, 8'h14, 32'hA5A5_00FF},
        '{8'h1C, 32'h0500_000F, 8'h14, 32'hA0A5_00F0},
        '{8'h1C, 32'h0000_0000, 8'h14, 32'hA0A5_00F0},
        '{8'h40, 32'h8000_0001, 8'h3C, 32'h8000_0001},
        '{8'h44, 32'hFFFF_FFFF, 8'h3C, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        sel = 0; we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        sel = 1; we = 0; addr = a;
        #1 d = rdata;
        sel = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic pin(input int p, input logic v);
        @(negedge clk);
        ext[p] = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1; sel = 0; we = 0; addr = 0; wdata = 0; ext = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 64'(pad_oe), 64'h0);
        chk("R1 irq lines", 64'({bank_irq, pin_irq}), 64'h0);
        rd_chk("R1 dir set0", 8'h10, 32'hFFFF_FFFF);
        rd_chk("R1 dir set1", 8'h38, 32'hFFFF_FFFF);
        rd_chk("R1 rise en set0 direct pins", 8'h24, 32'h0000_000F);
        rd_chk("R1 fall en set0 direct pins", 8'h30, 32'h0000_000F);
        rd_chk("R1 rise en set1", 8'h4C, 32'h0);
        rd_chk("R1 status set0", 8'h34, 32'h0);
        rd_chk("R1 R2 bank enable at 0x08", 8'h08, 32'h0);

        // R2 R3 vector walk
        foreach (VECS[i]) begin
            wr(VECS[i].waddr, VECS[i].wval);
            rd_chk("R3 latch readback", VECS[i].raddr, VECS[i].expect_v);
        end
        chk("R3 pad_out", 64'(pad_out), 64'h0000_0000_A0A5_00F0);

        // R4 direction
        wr(8'h10, 32'hFFFF_FBFF);
        chk("R4 pin 10 output enable", 64'(pad_oe), 64'h400);
        rd_chk("R4 dir readback", 8'h10, 32'hFFFF_FBFF);

        // R5 synchronizer latency on pin 40 (set1 bit 8)
        @(negedge clk);
        ext[40] = 1;
        @(posedge clk); #1;
        rd_chk("R5 in after one edge still old", 8'h48, 32'h0);
        @(posedge clk); #1;
        rd_chk("R5 in after two edges", 8'h48, 32'h0000_0100);
        // R5 loopback of an output pin
        wr(8'h18, 32'h0000_0400);
        @(posedge clk); @(posedge clk); #1;
        rd_chk("R5 output pin level readable", 8'h20, 32'h0000_0400);

        // R6 fall-only pin 33 (set1 bit1)
        wr(8'h54, 32'h2);
        pin(33, 1);
        rd_chk("R6 rise ignored when only fall enabled", 8'h5C, 32'h0);
        pin(33, 0);
        rd_chk("R6 fall sets status", 8'h5C, 32'h2);
        // both edges on pin 35 (bit3)
        wr(8'h4C, 32'h8);
        wr(8'h54, 32'h8);
        pin(35, 1);
        rd_chk("R6 both-edge pin on rise", 8'h5C, 32'hA);
        wr(8'h50, 32'h8);
        rd_chk("R6 rise enable cleared", 8'h4C, 32'h0);

        // R7 write-one-to-clear
        wr(8'h5C, 32'h2);
        rd_chk("R7 clear one bit", 8'h5C, 32'h8);
        wr(8'h5C, 32'h0);
        rd_chk("R7 zero mask keeps status", 8'h5C, 32'h8);
        wr(8'h5C, 32'h8);
        rd_chk("R7 clear last bit", 8'h5C, 32'h0);
        // edge wins over simultaneous clear
        wr(8'h4C, 32'h8);
        pin(35, 0);
        rd_chk("R7 status set before race", 8'h5C, 32'h8);
        @(negedge clk); ext[35] = 1;
        @(negedge clk);
        @(negedge clk); sel = 1; we = 1; addr = 8'h5C; wdata = 32'h8;
        @(negedge clk); sel = 0; we = 0;
        rd_chk("R7 edge wins over same-cycle clear", 8'h5C, 32'h8);
        wr(8'h5C, 32'h8);
        rd_chk("R7 clear without edge", 8'h5C, 32'h0);

        // R8 banks: pin 20 -> bank 1, pin 40 -> bank 2
        wr(8'h24, 32'h0010_0000);
        wr(8'h08, 32'h2);
        pin(20, 1);
        chk("R8 bank 1 line", 64'(bank_irq), 64'h2);
        wr(8'h4C, 32'h100);
        pin(40, 0);
        pin(40, 1);
        rd_chk("R8 pin 40 status", 8'h5C, 32'h100);
        chk("R8 disabled bank 2 stays low", 64'(bank_irq), 64'h2);
        wr(8'h08, 32'h6);
        chk("R8 bank 2 enabled", 64'(bank_irq), 64'h6);
        wr(8'h34, 32'h0010_0000);
        chk("R8 bank 1 drops after clear", 64'(bank_irq), 64'h4);
        wr(8'h5C, 32'h100);
        chk("R8 all banks low", 64'(bank_irq), 64'h0);

        // R9 direct lines
        wr(8'h08, 32'h0);
        pin(2, 1);
        chk("R9 direct line on rise", 64'(pin_irq), 64'h4);
        chk("R9 bank lines gated", 64'(bank_irq), 64'h0);
        wr(8'h34, 32'h4);
        chk("R9 direct line cleared", 64'(pin_irq), 64'h0);
        pin(2, 0);
        chk("R9 direct line on fall", 64'(pin_irq), 64'h4);
        wr(8'h34, 32'h4);

        // R10 unmapped addresses
        wr(8'hF0, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R10 unmapped read 0xF0", 8'hF0, 32'h0);
        rd_chk("R10 unmapped read 0x04", 8'h04, 32'h0);
        rd_chk("R10 bank enable untouched", 8'h08, 32'h0);
        rd_chk("R10 latch untouched", 8'h14, 32'hA0A5_04F0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule